// File: doc/BRIEF.md
# Receive FEC Codeword Deframer

This block watches a 320-bit receive bus that carries Reed-Solomon codewords made of 10-bit symbols. The bus is split into two 160-bit lanes of 16 symbols each. A codeword can begin in either lane. A lower-lane start strobe marks a codeword that begins in bits 159:0, and an upper-lane start strobe marks one that begins in bits 319:160. The bus holds data only on cycles where the enable input is high. Enable may drop on any cycle, including in the middle of a codeword.

For each codeword the block forwards the 514 message symbols in arrival order. It drops the parity symbols and anything that follows the end of a codeword. The mode input sets the codeword length to 544 symbols (34 lanes) or 528 symbols (33 lanes). In the 528-symbol mode, back-to-back codewords alternate between the lower and upper lane, so one cycle can carry the tail of one codeword and the head of the next. The block also latches the status flags that come with each codeword, and it does so without qualifying them by enable. A start strobe that arrives while a codeword is still open abandons that codeword and sets a sticky error bit.

Top module: `rxd_deframer`

## Requirements
- R1: While reset is active and until the first enabled input after release, `o_valid`, `o_last`, `o_flag_upd` and `o_abort_err` are all zero, and `o_flags`/`o_flagsb` are zero.
- R2: After an enabled start strobe, the message symbols leave on the same lane positions they arrived on, in the same order. Symbol j of the lower lane sits in bits [10j+9:10j], and the upper lane is offset by 160. Each enabled input lane holding at least one message symbol gives `o_valid` high for that lane on the next cycle.
- R3: The lane that holds message symbol 513 (the last one) has `o_last` set. In that lane only the two lowest symbol slots carry data and the other 14 slots read zero. Lanes that hold only parity never raise `o_valid`.
- R4: With `i_cw528` low a codeword spans 34 lanes; with it high it spans 33. After the last lane of a codeword, bus content produces no output until the next start strobe.
- R5: An upper-lane start strobe (`i_startb`) begins a codeword at the upper lane of that cycle. The lower lane of that cycle still belongs to the codeword in progress, so both lanes can be valid together and the lower lane can carry `o_last`.
- R6: On a cycle with `i_ena` low, no lane is valid on the next cycle, the position inside the current codeword is kept, and both start strobes are ignored for framing.
- R7: A start strobe on an enabled cycle while a codeword is still incomplete, including a lower and an upper strobe in the same cycle, abandons the older codeword, starts the new one, and sets `o_abort_err`. The error bit stays set until reset.
- R8: On every cycle where `i_start` (or `i_startb`) is high, whatever the value of `i_ena`, `i_flags` (or `i_flagsb`) is latched onto `o_flags` (or `o_flagsb`). On the next cycle `o_flag_upd[0]` (or `[1]`) is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_cw528 | input | 1 | 1: 528-symbol codewords, 0: 544-symbol codewords |
| i_ena | input | 1 | Bus data qualifier |
| i_start | input | 1 | Codeword starts in lower lane |
| i_startb | input | 1 | Codeword starts in upper lane |
| i_data | input | 320 | Receive bus, 32 symbols of 10 bits |
| i_flags | input | 8 | Status flags for a lower-lane codeword |
| i_flagsb | input | 8 | Status flags for an upper-lane codeword |
| o_valid | output | 2 | Per-lane message valid (bit 0 lower) |
| o_last | output | 2 | Per-lane last-message-lane marker |
| o_data | output | 320 | Message symbols, parity slots zeroed |
| o_abort_err | output | 1 | Sticky: a codeword was abandoned |
| o_flags | output | 8 | Latched lower-lane flags |
| o_flagsb | output | 8 | Latched upper-lane flags |
| o_flag_upd | output | 2 | One-cycle pulse: flags latched |

## Verification
Every result in this block appears exactly one clock after the input cycle that produced it. This covers lane validity, the last marker, the masked data, the abort flag and the flag latches with their update pulse. The bench applies each input at the falling edge and runs a symbol-position model in the same step. It then compares all outputs one nanosecond after the next rising edge, which is the first moment the single register stage shows the new values. Because enable gaps only postpone that comparison to a later cycle, the model and the design stay in step without any counting of latency.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // Integer ceiling division used for lane counts.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  typedef enum logic {
    CW_LEN_LONG  = 1'b0,
    CW_LEN_SHORT = 1'b1
  } cw_len_e;

endpackage

// File: rtl/rxd_lane.sv
module rxd_lane
  import rxd_pkg::*;
#(
  parameter int SYM_W     = 10,
  parameter int LANE_SYMS = 16,
  parameter int MSG_SYMS  = 514,
  parameter int IDX_W     = 6
) (
  input  logic                       act_in,
  input  logic [IDX_W-1:0]           idx_in,
  input  logic [IDX_W-1:0]           tot_lanes,
  input  logic                       strobe,
  input  logic [SYM_W*LANE_SYMS-1:0] data,
  output logic                       act_out,
  output logic [IDX_W-1:0]           idx_out,
  output logic                       abort,
  output logic                       msg_vld,
  output logic                       msg_last,
  output logic [SYM_W*LANE_SYMS-1:0] msg_data
);

  localparam int MSG_LANES = ceil_div(MSG_SYMS, LANE_SYMS);
  localparam int TAIL_SYMS = MSG_SYMS - (MSG_LANES - 1) * LANE_SYMS;

  logic             act_here;
  logic [IDX_W-1:0] idx_here;
  logic [IDX_W-1:0] idx_inc;

  always_comb begin
    act_here = strobe | act_in;
    idx_here = strobe ? '0 : idx_in;
    idx_inc  = idx_here + IDX_W'(1);
    abort    = strobe & act_in;
    msg_vld  = act_here && (idx_here < IDX_W'(MSG_LANES));
    msg_last = act_here && (idx_here == IDX_W'(MSG_LANES - 1));
    idx_out  = act_here ? idx_inc : idx_in;
    act_out  = act_here && (idx_inc < tot_lanes);
  end

  // Per-symbol masking: parity slots of the final message lane read zero.
  for (genvar s = 0; s < LANE_SYMS; s++) begin : g_sym
    localparam bit IN_TAIL = (s < TAIL_SYMS);
    logic keep;
    assign keep = msg_vld && (!msg_last || IN_TAIL);
    assign msg_data[s*SYM_W +: SYM_W] = keep ? data[s*SYM_W +: SYM_W] : '0;
  end

endmodule

// File: rtl/rxd_frame_ctl.sv
module rxd_frame_ctl #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena,
  input  logic             act_nxt,
  input  logic [IDX_W-1:0] idx_nxt,
  input  logic             abort_any,
  output logic             act_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             err_q
);

  logic             act_d;
  logic [IDX_W-1:0] idx_d;
  logic             err_d;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    err_d = err_q;
    if (ena) begin
      act_d = act_nxt;
      idx_d = idx_nxt;
      err_d = err_q | abort_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> ($stable(act_q) && $stable(idx_q)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7
  abort_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena && abort_any) |=> err_q);

endmodule

// File: rtl/rxd_flag_cap.sv
module rxd_flag_cap #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_a,
  input  logic              start_b,
  input  logic [FLAG_W-1:0] flags_a,
  input  logic [FLAG_W-1:0] flags_b,
  output logic [FLAG_W-1:0] held_a,
  output logic [FLAG_W-1:0] held_b,
  output logic [1:0]        upd
);

  logic [FLAG_W-1:0] held_a_d;
  logic [FLAG_W-1:0] held_b_d;

  always_comb begin
    held_a_d = start_a ? flags_a : held_a;
    held_b_d = start_b ? flags_b : held_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_a <= '0;
      held_b <= '0;
      upd    <= '0;
    end else begin
      held_a <= held_a_d;
      held_b <= held_b_d;
      upd    <= {start_b, start_a};
    end
  end

  // R8
  flag_a_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_a |=> (held_a == $past(flags_a)));

  // R8
  flag_b_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_b |=> (held_b == $past(flags_b)));

endmodule

// File: rtl/rxd_deframer.sv
module rxd_deframer
  import rxd_pkg::*;
#(
  parameter int SYM_W      = 10,
  parameter int LANE_SYMS  = 16,
  parameter int MSG_SYMS   = 514,
  parameter int LONG_SYMS  = 544,
  parameter int SHORT_SYMS = 528,
  parameter int FLAG_W     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_cw528,
  input  logic          i_ena,
  input  logic          i_start,
  input  logic          i_startb,
  input  logic [319:0]  i_data,
  input  logic [7:0]    i_flags,
  input  logic [7:0]    i_flagsb,
  output logic [1:0]    o_valid,
  output logic [1:0]    o_last,
  output logic [319:0]  o_data,
  output logic          o_abort_err,
  output logic [7:0]    o_flags,
  output logic [7:0]    o_flagsb,
  output logic [1:0]    o_flag_upd
);

  localparam int LANES       = 2;
  localparam int LANE_W      = SYM_W * LANE_SYMS;
  localparam int BUS_W       = LANE_W * LANES;
  localparam int LONG_LANES  = ceil_div(LONG_SYMS, LANE_SYMS);
  localparam int SHORT_LANES = ceil_div(SHORT_SYMS, LANE_SYMS);
  localparam int IDX_W       = $clog2(LONG_LANES + 1);

  // Synchronous release of the asynchronous reset.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  cw_len_e          cw_len;
  logic [IDX_W-1:0] tot_lanes;
  logic [LANES-1:0] strobe_v;

  assign cw_len    = cw_len_e'(i_cw528);
  assign tot_lanes = (cw_len == CW_LEN_SHORT) ? IDX_W'(SHORT_LANES) : IDX_W'(LONG_LANES);
  assign strobe_v  = {i_startb, i_start} & {LANES{i_ena}};

  logic                        act_q;
  logic [IDX_W-1:0]            idx_q;
  logic                        err_q;
  logic [LANES:0]              act_c;
  logic [LANES:0][IDX_W-1:0]   idx_c;
  logic [LANES-1:0]            abort_v;
  logic [LANES-1:0]            vld_v;
  logic [LANES-1:0]            last_v;
  logic [BUS_W-1:0]            data_v;

  assign act_c[0] = act_q;
  assign idx_c[0] = idx_q;

  // Lanes are chained: each lane continues the codeword state left by the one below.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxd_lane #(
      .SYM_W    (SYM_W),
      .LANE_SYMS(LANE_SYMS),
      .MSG_SYMS (MSG_SYMS),
      .IDX_W    (IDX_W)
    ) u_lane (
      .act_in   (act_c[g]),
      .idx_in   (idx_c[g]),
      .tot_lanes(tot_lanes),
      .strobe   (strobe_v[g]),
      .data     (i_data[g*LANE_W +: LANE_W]),
      .act_out  (act_c[g+1]),
      .idx_out  (idx_c[g+1]),
      .abort    (abort_v[g]),
      .msg_vld  (vld_v[g]),
      .msg_last (last_v[g]),
      .msg_data (data_v[g*LANE_W +: LANE_W])
    );
  end

  rxd_frame_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ena      (i_ena),
    .act_nxt  (act_c[LANES]),
    .idx_nxt  (idx_c[LANES]),
    .abort_any(|abort_v),
    .act_q    (act_q),
    .idx_q    (idx_q),
    .err_q    (err_q)
  );

  rxd_flag_cap #(.FLAG_W(FLAG_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start_a(i_start),
    .start_b(i_startb),
    .flags_a(i_flags),
    .flags_b(i_flagsb),
    .held_a (o_flags),
    .held_b (o_flagsb),
    .upd    (o_flag_upd)
  );

  assign o_abort_err = err_q;

  // Output stage: next-state and register processes.
  logic [LANES-1:0] valid_d;
  logic [LANES-1:0] last_d;
  logic [BUS_W-1:0] data_d;

  always_comb begin
    valid_d = i_ena ? vld_v  : '0;
    last_d  = i_ena ? last_v : '0;
    data_d  = i_ena ? data_v : o_data;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      o_valid <= '0;
      o_last  <= '0;
      o_data  <= '0;
    end else begin
      o_valid <= valid_d;
      o_last  <= last_d;
      o_data  <= data_d;
    end
  end

  // R6
  no_out_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !i_ena |=> (o_valid == '0));

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (o_last & ~o_valid) == '0);

  // R3
  single_last_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(o_last) <= 1);

endmodule

// File: tb/rxd_deframer_bench.sv
`timescale 1ns/1ps
module rxd_deframer_bench;

  localparam int MSG = 514;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         i_cw528, i_ena, i_start, i_startb;
  logic [319:0] i_data;
  logic [7:0]   i_flags, i_flagsb;
  logic [1:0]   o_valid, o_last, o_flag_upd;
  logic [319:0] o_data;
  logic         o_abort_err;
  logic [7:0]   o_flags, o_flagsb;

  always #2.5 clk = ~clk;

  rxd_deframer u_rxd_deframer (
    .clk(clk), .rst_n(rst_n), .i_cw528(i_cw528), .i_ena(i_ena),
    .i_start(i_start), .i_startb(i_startb), .i_data(i_data),
    .i_flags(i_flags), .i_flagsb(i_flagsb), .o_valid(o_valid),
    .o_last(o_last), .o_data(o_data), .o_abort_err(o_abort_err),
    .o_flags(o_flags), .o_flagsb(o_flagsb), .o_flag_upd(o_flag_upd)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   pos = -1;
  int   cyc_n = 0;
  bit   m_err = 0;
  logic [7:0] m_fa = '0;
  logic [7:0] m_fb = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One input cycle: drive at falling edge, model, compare after next rising edge.
  task automatic step(input bit en, input bit st, input bit stb, input string tag);
    logic [1:0]   ev, el, eu;
    logic [319:0] ed;
    int tot;
    @(negedge clk);
    cyc_n++;
    i_ena = en; i_start = st; i_startb = stb;
    for (int k = 0; k < 32; k++) i_data[k*10 +: 10] = 10'(cyc_n*37 + k*5 + 1);
    i_flags  = 8'(cyc_n*3);
    i_flagsb = 8'(cyc_n*7 + 1);
    ev = '0; el = '0; ed = '0;
    eu = {stb, st};
    if (st)  m_fa = i_flags;
    if (stb) m_fb = i_flagsb;
    tot = i_cw528 ? 528 : 544;
    if (en) begin
      for (int l = 0; l < 2; l++) begin
        if ((l == 0) ? st : stb) begin
          if (pos >= 0) m_err = 1;
          pos = 0;
        end
        if (pos >= 0) begin
          for (int s = 0; s < 16; s++) begin
            if (pos + s < MSG) begin
              ev[l] = 1'b1;
              ed[l*160 + s*10 +: 10] = i_data[l*160 + s*10 +: 10];
            end
            if (pos + s == MSG - 1) el[l] = 1'b1;
          end
          pos += 16;
          if (pos >= tot) pos = -1;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(o_valid == ev, {"R2 ", tag}, "valid", 320'(o_valid), 320'(ev));
    chk(o_last == el, {"R3 ", tag}, "last", 320'(o_last), 320'(el));
    for (int l = 0; l < 2; l++)
      if (ev[l])
        chk(o_data[l*160 +: 160] == ed[l*160 +: 160], {"R2 ", tag}, "data",
            320'(o_data[l*160 +: 160]), 320'(ed[l*160 +: 160]));
    chk(o_abort_err == m_err, {"R7 ", tag}, "abort_err", 320'(o_abort_err), 320'(m_err));
    chk(o_flag_upd == eu, {"R8 ", tag}, "flag_upd", 320'(o_flag_upd), 320'(eu));
    chk(o_flags == m_fa && o_flagsb == m_fb, {"R8 ", tag}, "flags",
        320'({o_flagsb, o_flags}), 320'({m_fb, m_fa}));
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; i_cw528 = 1'b0; i_ena = 1'b0; i_start = 1'b0; i_startb = 1'b0;
    i_data = '0; i_flags = '0; i_flagsb = '0;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(o_valid == 0 && o_last == 0, "R1", "valid/last in reset", 320'({o_valid, o_last}), 320'(0));
    chk(o_abort_err == 0 && o_flag_upd == 0, "R1", "err/upd in reset",
        320'({o_abort_err, o_flag_upd}), 320'(0));
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(o_valid == 0 && o_flags == 0 && o_flagsb == 0, "R1", "after release",
        320'({o_valid, o_flags, o_flagsb}), 320'(0));

    // R2, R4: one long codeword, then trailing bus content ignored
    step(1, 1, 0, "R2");
    repeat (16) step(1, 0, 0, "R4");
    repeat (3) step(1, 0, 0, "R4");

    // R6: enable gaps inside a codeword, strobes while disabled
    step(1, 1, 0, "R6");
    for (int i = 0; i < 40; i++) step(i % 3 != 2, 0, 0, "R6");
    step(0, 1, 0, "R6");
    step(0, 0, 1, "R6");
    repeat (2) step(1, 0, 0, "R6");

    // R5, R4: short codewords alternating lanes back to back
    i_cw528 = 1'b1;
    step(1, 1, 0, "R5");
    repeat (7) step(1, 0, 0, "R5");
    step(0, 0, 0, "R5");
    repeat (8) step(1, 0, 0, "R5");
    step(1, 0, 1, "R5");
    repeat (16) step(1, 0, 0, "R5");
    step(1, 1, 0, "R5");
    repeat (16) step(1, 0, 0, "R5");
    repeat (2) step(1, 0, 0, "R4");

    // R7: abort by early start, then both strobes in one cycle
    i_cw528 = 1'b0;
    step(1, 1, 0, "R7");
    repeat (5) step(1, 0, 0, "R7");
    step(1, 1, 0, "R7");
    repeat (3) step(1, 0, 0, "R7");
    step(1, 1, 1, "R7");
    repeat (20) step(1, 0, 0, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule